// File: doc/BRIEF.md
# Serial Receive Two-Deep Buffer with Per-Word Status

This block sits between the deserialiser of an asynchronous serial receiver and the processor's read port. Each completed frame arrives as a single-cycle strobe carrying eight data bits, a ninth data bit and a framing-error flag. The frame is placed into a two-entry circular queue. The processor sees the oldest word together with its own ninth bit, framing flag and overrun flag. A read strobe removes that word, so every word is delivered once.

When both queue slots are occupied, a newly completed frame is not discarded. It stays in the deserialiser's shift register, which acts as a third storage level. An output tells the deserialiser that it is holding such a frame. The held frame enters the queue on the clock after a slot frees. It is lost only if a new start bit arrives while the queue is still full. That loss is recorded on the next word that enters the queue. Dropping the enable empties all three levels and clears every stored flag.

Top module: `serial_rx_buffer`

## Requirements
- R1: After reset the queue is empty, no frame is held, and every read-side output is 0.
- R2: Words leave the queue in arrival order. A read strobe on a non-empty queue removes the oldest word, and each word is presented exactly once.
- R3: The ninth bit and the framing flag shown on the read side are the values that arrived with the word currently at the head of the queue.
- R4: `rx_done` is 1 exactly when the queue holds at least one word. It falls in the cycle after the last word is read.
- R5: While the queue is empty, `rd_data`, `rd_bit9`, `rd_ferr` and `rd_ovr` are all 0. A read strobe on an empty queue has no effect, and the next arriving word is presented normally.
- R6: A frame that completes while the queue is full is kept in the shift-register level (`sh_hold` = 1), and the queue contents are unchanged.
- R7: A held frame enters the queue at the first clock edge at which the queue was not full. After a read frees a slot, `sh_hold` therefore stays 1 for one more cycle and then falls.
- R8: A start-bit strobe while the queue is full, a frame is held and no read occurs discards the held frame: `sh_hold` falls, and the queue is unchanged.
- R9: After a discard, the next word to enter the queue carries `rd_ovr` = 1. Words already in the queue and later words carry `rd_ovr` = 0.
- R10: A start-bit strobe when no frame is held, or when a slot is free, records no overrun.
- R11: A start-bit strobe in the same cycle as a read, while the queue is full and a frame is held, moves the held frame into the freed slot at that same edge. No overrun is recorded.
- R12: While `rx_en` is 0, the queue, the held frame and any recorded overrun are cleared, and arriving frames are ignored.
- R13: A frame completing while an earlier frame is still held (with no start-bit strobe in between) replaces the held frame. The replacement counts as an overrun for R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes all storage |
| frm_vld | input | 1 | Frame-complete strobe from the shift register |
| frm_data | input | DATA_W | Data bits of the completed frame |
| frm_bit9 | input | 1 | Ninth data bit of the completed frame |
| frm_ferr | input | 1 | Framing error of the completed frame |
| start_det | input | 1 | Start-bit-detected strobe |
| rd_pop | input | 1 | Processor data read; removes the head word |
| rd_data | output | DATA_W | Head word data, 0 when empty |
| rd_bit9 | output | 1 | Ninth bit of head word |
| rd_ferr | output | 1 | Framing flag of head word |
| rd_ovr | output | 1 | Overrun flag of head word |
| rx_done | output | 1 | Queue holds at least one word |
| sh_hold | output | 1 | Shift-register level holds a frame waiting for a slot |

## Verification
A start-bit strobe and a processor read can occur in the same cycle while the queue is full and a frame is held. Here the overrun decision and the slot release interact. The bench fills both slots plus the held level, then drives `start_det` and `rd_pop` on the same edge. It then expects the second word at the head, `sh_hold` low, and the held word to arrive next with no overrun mark. A separate case drives the start strobe without the read and expects the held frame to be lost and the next word to be marked as an overrun.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  // Status carried alongside every stored word.
  typedef struct packed {
    logic ovr;
    logic ferr;
    logic bit9;
  } rxb_tag_t;

  localparam rxb_tag_t RXB_TAG_CLR = '0;

endpackage

// File: rtl/rxb_store.sv
module rxb_store
  import rxb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  rxb_tag_t          wr_tag,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output rxb_tag_t          head_tag,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  occ
);

  logic [DATA_W-1:0] data_q [DEPTH];
  rxb_tag_t          tag_q  [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign occ   = cnt_q;
  assign pop   = pop_req & ~empty;

  // Next-state for pointers and occupancy.
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (wr_en) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop)   rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({wr_en, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Per-entry status: reset and flushed to clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= RXB_TAG_CLR;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (flush)
          tag_q[i] <= RXB_TAG_CLR;
        else if (wr_en && (wr_ptr_q == PTR_W'(i)))
          tag_q[i] <= wr_tag;
      end
    end
  end

  // Data storage: write-enabled only, no reset needed.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!flush && wr_en && (wr_ptr_q == PTR_W'(i)))
        data_q[i] <= wr_data;
    end
  end

  assign head_data = empty ? '0 : data_q[rd_ptr_q];
  assign head_tag  = empty ? RXB_TAG_CLR : tag_q[rd_ptr_q];

endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
  import rxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              frm_vld,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_bit9,
  input  logic              frm_ferr,
  input  logic              start_det,
  input  logic              pop_req,
  input  logic              full,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output rxb_tag_t          wr_tag,
  output logic              hold_vld
);

  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pdata_q;
  logic              pb9_q, pfe_q;
  logic              ovr_q, ovr_d;
  logic              load_pend;
  logic              move_pend, direct, rescue, lose, replace;

  always_comb begin
    rescue    = enable & start_det & pend_q & full & pop_req;
    lose      = enable & start_det & pend_q & full & ~pop_req;
    move_pend = enable & pend_q & (~full | rescue);
    direct    = enable & frm_vld & ~pend_q & ~full;
    replace   = enable & frm_vld & pend_q & ~move_pend;
    load_pend = enable & frm_vld & ~direct;
    wr_en     = move_pend | direct;

    wr_data     = pend_q ? pdata_q : frm_data;
    wr_tag.bit9 = pend_q ? pb9_q : frm_bit9;
    wr_tag.ferr = pend_q ? pfe_q : frm_ferr;
    wr_tag.ovr  = ovr_q;

    if (!enable)                pend_d = 1'b0;
    else if (load_pend)         pend_d = 1'b1;
    else if (move_pend || lose) pend_d = 1'b0;
    else                        pend_d = pend_q;

    ovr_d = enable & ((ovr_q & ~wr_en) | lose | replace);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_pend) begin
      pdata_q <= frm_data;
      pb9_q   <= frm_bit9;
      pfe_q   <= frm_ferr;
    end
  end

  assign hold_vld = pend_q;

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
  import rxb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              frm_vld,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_bit9,
  input  logic              frm_ferr,
  input  logic              start_det,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              rd_ovr,
  output logic              rx_done,
  output logic              sh_hold
);

  logic              wr_en_w;
  logic [DATA_W-1:0] wr_data_w;
  rxb_tag_t          wr_tag_w;
  rxb_tag_t          head_tag_w;
  logic              full_w, empty_w;
  logic [OCC_W-1:0]  occ_w;

  rxb_hold #(.DATA_W(DATA_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (rx_en),
    .frm_vld   (frm_vld),
    .frm_data  (frm_data),
    .frm_bit9  (frm_bit9),
    .frm_ferr  (frm_ferr),
    .start_det (start_det),
    .pop_req   (rd_pop),
    .full      (full_w),
    .wr_en     (wr_en_w),
    .wr_data   (wr_data_w),
    .wr_tag    (wr_tag_w),
    .hold_vld  (sh_hold)
  );

  rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (~rx_en),
    .wr_en     (wr_en_w),
    .wr_data   (wr_data_w),
    .wr_tag    (wr_tag_w),
    .pop_req   (rd_pop & rx_en),
    .head_data (rd_data),
    .head_tag  (head_tag_w),
    .full      (full_w),
    .empty     (empty_w),
    .occ       (occ_w)
  );

  assign rd_bit9 = head_tag_w.bit9;
  assign rd_ferr = head_tag_w.ferr;
  assign rd_ovr  = head_tag_w.ovr;
  assign rx_done = ~empty_w;

endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int OCC_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              frm_vld,
  input logic              start_det,
  input logic              rd_pop,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_bit9,
  input logic              rd_ferr,
  input logic              rd_ovr,
  input logic              rx_done,
  input logic              sh_hold,
  input logic              full,
  input logic [OCC_W-1:0]  occ,
  input logic              wr_en
);

  a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  a_r4_last_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && occ == OCC_W'(1) && rd_pop && !wr_en |=> !rx_done);

  a_r5_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> (rd_data == '0) && !rd_bit9 && !rd_ferr && !rd_ovr);

  a_r6_hold_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && frm_vld && (full || sh_hold) |=> sh_hold);

  a_r7_move_in: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && sh_hold && !full && !frm_vld |=> !sh_hold);

  a_r8_overrun_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && start_det && sh_hold && full && !rd_pop && !frm_vld |=> !sh_hold && full);

  a_r11_rescue: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && start_det && sh_hold && full && rd_pop && !frm_vld |=> !sh_hold && full);

  a_r12_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_done && !sh_hold);

endmodule

bind serial_rx_buffer rxb_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OCC_W(OCC_W)) i_rxb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .frm_vld   (frm_vld),
  .start_det (start_det),
  .rd_pop    (rd_pop),
  .rd_data   (rd_data),
  .rd_bit9   (rd_bit9),
  .rd_ferr   (rd_ferr),
  .rd_ovr    (rd_ovr),
  .rx_done   (rx_done),
  .sh_hold   (sh_hold),
  .full      (full_w),
  .occ       (occ_w),
  .wr_en     (wr_en_w)
);

// File: tb/test_serial_rx_buffer.sv
module test_serial_rx_buffer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en;
  logic       frm_vld;
  logic [7:0] frm_data;
  logic       frm_bit9;
  logic       frm_ferr;
  logic       start_det;
  logic       rd_pop;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_ferr, rd_ovr, rx_done, sh_hold;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_rx_buffer i_serial_rx_buffer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .frm_vld(frm_vld), .frm_data(frm_data), .frm_bit9(frm_bit9), .frm_ferr(frm_ferr),
    .start_det(start_det), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr), .rd_ovr(rd_ovr),
    .rx_done(rx_done), .sh_hold(sh_hold)
  );

  // One clock: inputs applied at a falling edge, outputs seen at the next one.
  task automatic tick(input logic fv, input logic [7:0] d, input logic b9,
                      input logic fe, input logic st, input logic pp);
    frm_vld = fv; frm_data = d; frm_bit9 = b9; frm_ferr = fe;
    start_det = st; rd_pop = pp;
    @(negedge clk);
    frm_vld = 1'b0; frm_data = '0; frm_bit9 = 1'b0; frm_ferr = 1'b0;
    start_det = 1'b0; rd_pop = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic b9, input logic fe);
    tick(1'b1, d, b9, fe, 1'b0, 1'b0);
  endtask

  task automatic pop1();
    tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic idle();
    tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // Compares {hold, done, ovr, ferr, bit9, data}.
  task automatic expect_out(input string req, input logic hold, input logic done,
                            input logic ov, input logic fe, input logic b9,
                            input logic [7:0] d);
    logic [12:0] act, exp;
    act = {sh_hold, rx_done, rd_ovr, rd_ferr, rd_bit9, rd_data};
    exp = {hold, done, ov, fe, b9, d};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    expect_out("R1 reset state", 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_order();
    push(8'hA1, 1'b1, 1'b0);
    expect_out("R4 done after first word", 0, 1, 0, 0, 1, 8'hA1);
    push(8'hB2, 1'b0, 1'b1);
    expect_out("R2 head stays oldest", 0, 1, 0, 0, 1, 8'hA1);
    pop1();
    expect_out("R3 second word flags", 0, 1, 0, 1, 0, 8'hB2);
    pop1();
    expect_out("R4 done falls after last read", 0, 0, 0, 0, 0, 8'h00);
    pop1();
    expect_out("R5 read on empty ignored", 0, 0, 0, 0, 0, 8'h00);
    push(8'h3C, 1'b1, 1'b1);
    expect_out("R5 word after empty read", 0, 1, 0, 1, 1, 8'h3C);
    pop1();
    expect_out("R2 drained", 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_hold();
    push(8'h11, 1'b0, 1'b0);
    push(8'h22, 1'b0, 1'b0);
    push(8'h33, 1'b1, 1'b0);
    expect_out("R6 third frame held", 1, 1, 0, 0, 0, 8'h11);
    pop1();
    expect_out("R7 still held on read edge", 1, 1, 0, 0, 0, 8'h22);
    idle();
    expect_out("R7 moved next clock", 0, 1, 0, 0, 0, 8'h22);
    pop1();
    expect_out("R6 held frame not lost", 0, 1, 0, 0, 1, 8'h33);
    pop1();
    expect_out("R2 drained", 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_overrun();
    push(8'h41, 1'b0, 1'b0);
    push(8'h42, 1'b0, 1'b0);
    push(8'h43, 1'b0, 1'b0);
    tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R8 held frame dropped", 0, 1, 0, 0, 0, 8'h41);
    push(8'h44, 1'b0, 1'b0);
    expect_out("R9 old entries unmarked", 1, 1, 0, 0, 0, 8'h41);
    pop1();
    expect_out("R9 second old entry unmarked", 1, 1, 0, 0, 0, 8'h42);
    idle();
    pop1();
    expect_out("R9 next word marked", 0, 1, 1, 0, 0, 8'h44);
    push(8'h45, 1'b1, 1'b0);
    pop1();
    expect_out("R9 mark only once", 0, 1, 0, 0, 1, 8'h45);
    pop1();
    expect_out("R2 drained", 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_no_overrun();
    push(8'h51, 1'b0, 1'b0);
    push(8'h52, 1'b0, 1'b0);
    tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R10 start when full, nothing held", 0, 1, 0, 0, 0, 8'h51);
    push(8'h53, 1'b0, 1'b1);
    pop1();
    tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R10 start with free slot moves frame", 0, 1, 0, 0, 0, 8'h52);
    pop1();
    expect_out("R10 no overrun mark", 0, 1, 0, 1, 0, 8'h53);
    pop1();
  endtask

  task automatic t_rescue();
    push(8'h61, 1'b0, 1'b0);
    push(8'h62, 1'b1, 1'b0);
    push(8'h63, 1'b0, 1'b1);
    tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_out("R11 same-edge move", 0, 1, 0, 0, 1, 8'h62);
    pop1();
    expect_out("R11 rescued word unmarked", 0, 1, 0, 1, 0, 8'h63);
    pop1();
    expect_out("R11 drained", 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_replace();
    push(8'h71, 1'b0, 1'b0);
    push(8'h72, 1'b0, 1'b0);
    push(8'h73, 1'b0, 1'b0);
    push(8'h74, 1'b1, 1'b0);
    expect_out("R13 replacement held", 1, 1, 0, 0, 0, 8'h71);
    pop1();
    idle();
    pop1();
    expect_out("R13 replacement marked", 0, 1, 1, 0, 1, 8'h74);
    pop1();
    expect_out("R13 drained", 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_flush();
    push(8'h81, 1'b1, 1'b1);
    push(8'h82, 1'b0, 1'b0);
    push(8'h83, 1'b0, 1'b0);
    tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    push(8'h84, 1'b0, 1'b0);
    rx_en = 1'b0;
    idle();
    expect_out("R12 flush clears all", 0, 0, 0, 0, 0, 8'h00);
    push(8'h85, 1'b1, 1'b1);
    expect_out("R12 frame ignored while off", 0, 0, 0, 0, 0, 8'h00);
    rx_en = 1'b1;
    push(8'h86, 1'b0, 1'b0);
    expect_out("R12 overrun cleared by flush", 0, 1, 0, 0, 0, 8'h86);
    pop1();
    expect_out("R12 drained", 0, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b1;
    frm_vld = 1'b0; frm_data = '0; frm_bit9 = 1'b0; frm_ferr = 1'b0;
    start_det = 1'b0; rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_hold();
    t_overrun();
    t_no_overrun();
    t_rescue();
    t_replace();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule